// File: doc/BRIEF.md
# Normalized Min-Sum Check Node Unit

This unit produces the check-to-bit messages of one parity-check node in an iterative LDPC decoder. It uses the normalized min-sum rule. Bit-to-check messages arrive one per cycle over a valid/ready input. The first message of a node is marked and carries the node's degree. Once the last message of a node has been taken in, the unit returns one extrinsic message per edge, in the same order the edges arrived.

Every output leaves out its own edge's input. Its magnitude is the smallest magnitude among the other edges of the node, scaled by 3/4. Its sign is the product of the other edges' signs. Each node is reduced on the fly to four values: a smallest and a second-smallest magnitude, the position of the smallest, and a sign parity. The per-edge sign bits are also kept. The summary of a finished node is handed to a second register set, so the unit can take in the next node while it still emits the current one.

Top module: `nms_check_unit`

## Requirements
- R1: The input value -32 is treated as magnitude 31 with a negative sign. Every other input keeps its two's complement value.
- R2: The output magnitude for edge i, before scaling, is the minimum magnitude over all other edges of the same node. For a node with a single edge it is 31.
- R3: The scaled magnitude is floor(3*m/4), so no output magnitude exceeds 23.
- R4: The output sign for edge i is the XOR of the sign bits of all other edges of the node. Outputs are two's complement 6-bit values.
- R5: A node of degree d yields exactly d outputs in arrival order. out_first is high on edge 0 and out_last is high on edge d-1.
- R6: in_deg is sampled only with the message that has in_first high. Degrees 1 to 8 are supported, and a degree of 0 is handled as 1.
- R7: The unit takes in the next node while still emitting the previous one. in_ready is low only when a finished node is waiting and the output stage is still busy.
- R8: For in_deg above 8, messages after the eighth are consumed but do not affect the result. err_overdeg pulses for one cycle, one cycle after each such message. The node closes after in_deg messages and emits 8 outputs.
- R9: A message without in_first, accepted while no node is open, is discarded.
- R10: A message with in_first always opens a new node, and drops any node that was partly received.
- R11: While out_valid is high and out_ready is low, out_llr, out_first and out_last hold their values.
- R12: After reset, out_valid and err_overdeg are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input message valid |
| in_ready | output | 1 | Unit can take an input message |
| in_first | input | 1 | Message is edge 0 of a new node |
| in_deg | input | 4 | Node degree, sampled with in_first |
| in_llr | input | 6 | Bit-to-check message, two's complement |
| out_valid | output | 1 | Output message valid |
| out_ready | input | 1 | Consumer takes the output message |
| out_first | output | 1 | Output is edge 0 of its node |
| out_last | output | 1 | Output is the last edge of its node |
| out_llr | output | 6 | Check-to-bit message, two's complement |
| err_overdeg | output | 1 | Pulse: a message beyond the eighth edge was dropped |

## Verification
A corrupted minimum, second minimum or minimum position shows up within the output pass of the affected node. The edge holding the smallest input then gets the wrong magnitude, or the other edges do. A wrong sign parity flips every sign of that node. A fault in the edge counter or the degree register shows as a wrong out_last position, or as a missing or extra output, no later than the next node. A fault in the hand-off between the two register sets shows as a stalled in_ready or as outputs from a dropped node.

// File: rtl/nms_check_unit.sv
`timescale 1ns/1ps
module nms_check_unit #(
  parameter int W      = 6,
  parameter int MAXDEG = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic                          in_first,
  input  logic [$clog2(MAXDEG):0]       in_deg,
  input  logic signed [W-1:0]           in_llr,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic                          out_first,
  output logic                          out_last,
  output logic signed [W-1:0]           out_llr,
  output logic                          err_overdeg
);
  localparam int MW     = W - 1;
  localparam int IW     = $clog2(MAXDEG);
  localparam int CW     = IW + 1;
  localparam int MAXMAG = (1 << MW) - 1;

  logic              c_open, c_full, c_par;
  logic [CW-1:0]     c_cnt, c_deg;
  logic [MW-1:0]     c_min1, c_min2;
  logic [IW-1:0]     c_idx;
  logic [MAXDEG-1:0] c_sgn;

  logic              ob_busy, ob_par;
  logic [IW-1:0]     ob_idx, ob_pos;
  logic [CW-1:0]     ob_deg;
  logic [MW-1:0]     ob_min1, ob_min2;
  logic [MAXDEG-1:0] ob_sgn;

  logic          out_fire, ob_last, xfer, take, store, fin, keep, in_sgn;
  logic [CW-1:0] pos, pos_inc, deg_now;
  logic [W-1:0]  in_neg;
  logic [MW-1:0] in_mag, b_min1, b_min2, n_min1, n_min2;
  logic [IW-1:0] b_idx, n_idx;

  assign out_fire = out_valid && out_ready;
  assign ob_last  = (CW'(ob_idx) + CW'(1)) == ob_deg;
  assign xfer     = c_full && (!ob_busy || (out_fire && ob_last));
  assign in_ready = !c_full || xfer;
  assign take     = in_valid && in_ready && (in_first || c_open);

  assign pos     = in_first ? '0 : c_cnt;
  assign deg_now = in_first ? ((in_deg == '0) ? CW'(1) : in_deg) : c_deg;
  assign pos_inc = pos + CW'(1);
  assign fin     = pos_inc == deg_now;
  assign keep    = pos < CW'(MAXDEG);
  assign store   = take && keep;

  assign in_sgn = in_llr[W-1];
  assign in_neg = W'(0) - in_llr;
  assign in_mag = !in_sgn ? in_llr[MW-1:0] :
                  (in_llr[MW-1:0] == '0) ? MW'(MAXMAG) : in_neg[MW-1:0];

  assign b_min1 = in_first ? MW'(MAXMAG) : c_min1;
  assign b_min2 = in_first ? MW'(MAXMAG) : c_min2;
  assign b_idx  = in_first ? '0 : c_idx;

  always_comb begin
    n_min1 = b_min1;
    n_min2 = b_min2;
    n_idx  = b_idx;
    if (in_mag < b_min1) begin
      n_min1 = in_mag;
      n_min2 = b_min1;
      n_idx  = pos[IW-1:0];
    end else if (in_mag < b_min2) begin
      n_min2 = in_mag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_open      <= 1'b0;
      c_full      <= 1'b0;
      c_cnt       <= '0;
      c_deg       <= '0;
      c_min1      <= '0;
      c_min2      <= '0;
      c_idx       <= '0;
      c_par       <= 1'b0;
      c_sgn       <= '0;
      err_overdeg <= 1'b0;
    end else begin
      if (xfer) c_full <= 1'b0;
      if (take) begin
        c_cnt  <= pos_inc;
        c_deg  <= deg_now;
        c_open <= !fin;
        if (fin) c_full <= 1'b1;
      end
      if (store) begin
        c_min1 <= n_min1;
        c_min2 <= n_min2;
        c_idx  <= n_idx;
        c_par  <= (in_first ? 1'b0 : c_par) ^ in_sgn;
        c_sgn[pos[IW-1:0]] <= in_sgn;
      end
      err_overdeg <= take && !keep;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_busy <= 1'b0;
      ob_idx  <= '0;
      ob_pos  <= '0;
      ob_deg  <= '0;
      ob_min1 <= '0;
      ob_min2 <= '0;
      ob_par  <= 1'b0;
      ob_sgn  <= '0;
    end else if (xfer) begin
      ob_busy <= 1'b1;
      ob_idx  <= '0;
      ob_pos  <= c_idx;
      ob_deg  <= (c_deg > CW'(MAXDEG)) ? CW'(MAXDEG) : c_deg;
      ob_min1 <= c_min1;
      ob_min2 <= c_min2;
      ob_par  <= c_par;
      ob_sgn  <= c_sgn;
    end else if (out_fire) begin
      if (ob_last) ob_busy <= 1'b0;
      else         ob_idx  <= ob_idx + IW'(1);
    end
  end

  logic [MW-1:0] sel_mag, sc_mag;
  logic [MW+1:0] triple;
  logic [W-1:0]  mag_ext;
  logic          sgn_o;

  assign sel_mag   = (ob_idx == ob_pos) ? ob_min2 : ob_min1;
  assign triple    = {2'b00, sel_mag} + {1'b0, sel_mag, 1'b0};
  assign sc_mag    = triple[MW+1:2];
  assign mag_ext   = {1'b0, sc_mag};
  assign sgn_o     = ob_par ^ ob_sgn[ob_idx];
  assign out_llr   = sgn_o ? (W'(0) - mag_ext) : mag_ext;
  assign out_valid = ob_busy;
  assign out_first = ob_idx == '0;
  assign out_last  = ob_last;
endmodule

// File: rtl/nms_check_unit_chk.sv
`timescale 1ns/1ps
module nms_check_unit_chk #(
  parameter int W = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic                 out_first,
  input logic                 out_last,
  input logic signed [W-1:0]  out_llr,
  input logic                 err_overdeg
);
  localparam int BOUND = (3 * ((1 << (W - 1)) - 1)) / 4;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_llr) && $stable(out_first) && $stable(out_last))); // R11

  AST_MAG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((int'(out_llr) <= BOUND) && (int'(out_llr) >= -BOUND))); // R3

  AST_NEXT_STARTS_NODE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (!out_valid || out_first)); // R5

  AST_MID_NODE_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_valid && !out_first)); // R5

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_overdeg |-> $past(in_valid && in_ready)); // R8

  AST_READY_WHEN_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R7
endmodule

bind nms_check_unit nms_check_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_first(out_first),
  .out_last(out_last), .out_llr(out_llr), .err_overdeg(err_overdeg)
);

// File: tb/nms_check_unit_bench.sv
`timescale 1ns/1ps
module nms_check_unit_bench;
  localparam int NV = 8;
  // columns: degree, 8 inputs, 8 expected outputs
  localparam int TBL [NV][17] = '{
    '{6, 10, -5, 20, 3, -17, 8, 0, 0,        2, -2, 2, 3, -2, 2, 0, 0},
    '{7, -32, 31, 4, 4, -9, 12, 7, 0,        -3, 3, 3, 3, -3, 3, 3, 0},
    '{8, 0, 5, -6, 7, -8, 9, -10, 11,        -3, 0, 0, 0, 0, 0, 0, 0},
    '{6, -32, -32, -32, -32, -32, -32, 0, 0, -23, -23, -23, -23, -23, -23, 0, 0},
    '{2, 13, -2, 0, 0, 0, 0, 0, 0,           -1, 9, 0, 0, 0, 0, 0, 0},
    '{1, -5, 0, 0, 0, 0, 0, 0, 0,            23, 0, 0, 0, 0, 0, 0, 0},
    '{7, 9, 8, 7, 6, 5, 4, -3, 0,            -2, -2, -2, -2, -2, -2, 3, 0},
    '{0, 7, 0, 0, 0, 0, 0, 0, 0,             23, 0, 0, 0, 0, 0, 0, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, out_ready = 1'b0;
  logic [3:0] in_deg = '0;
  logic signed [5:0] in_llr = '0;
  logic in_ready, out_valid, out_first, out_last, err_overdeg;
  logic signed [5:0] out_llr;

  always #10 clk = ~clk;

  nms_check_unit u_nms_check_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_deg(in_deg), .in_llr(in_llr),
    .out_valid(out_valid), .out_ready(out_ready), .out_first(out_first),
    .out_last(out_last), .out_llr(out_llr), .err_overdeg(err_overdeg)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, mode = 0, err_seen = 0, last_out = 0;
  int    exp_llr[$];
  bit    exp_first[$], exp_last[$];
  string exp_tag[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic push(input int v, input bit f, input bit l, input string tag);
    exp_llr.push_back(v); exp_first.push_back(f); exp_last.push_back(l); exp_tag.push_back(tag);
  endtask

  task automatic send_msg(input bit f, input int d, input int v);
    bit done = 1'b0;
    while (!done) begin
      @(negedge clk);
      in_valid = 1'b1; in_first = f; in_deg = 4'(d); in_llr = 6'(v);
      #5;
      if (in_ready) begin
        @(posedge clk);
        done = 1'b1;
      end
    end
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && exp_llr.size() != 0; i++) @(posedge clk);
    repeat (3) @(posedge clk);
    chk(exp_llr.size() == 0, "R5 missing outputs", exp_llr.size(), 0);
  endtask

  task automatic run_table();
    for (int v = 0; v < NV; v++) begin
      int n;
      string tag;
      n = (TBL[v][0] == 0) ? 1 : TBL[v][0];
      case (v)
        1: tag = "R1 saturation vec1";
        2: tag = "R2 zero-min vec2";
        5: tag = "R6 degree-one vec5";
        7: tag = "R6 degree-zero vec7";
        default: tag = $sformatf("R2/R3/R4 vec%0d", v);
      endcase
      for (int e = 0; e < n; e++) push(TBL[v][9+e], e == 0, e == n - 1, tag);
      for (int e = 0; e < n; e++) send_msg(e == 0, TBL[v][0], TBL[v][1+e]);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      @(negedge clk);
      out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? ((cyc % 3) != 0) : 1'b0;
      #5;
      if (rst_n && err_overdeg) err_seen++;
      if (rst_n && out_valid && out_ready) begin
        last_out = cyc;
        if (exp_llr.size() == 0) begin
          chk(1'b0, "R5 unexpected output", int'(out_llr), 0);
        end else begin
          chk(int'(out_llr) == exp_llr[0], exp_tag[0], int'(out_llr), exp_llr[0]);
          chk(out_first == exp_first[0], "R5 out_first", out_first, exp_first[0]);
          chk(out_last == exp_last[0], "R5 out_last", out_last, exp_last[0]);
          void'(exp_llr.pop_front()); void'(exp_first.pop_front());
          void'(exp_last.pop_front()); void'(exp_tag.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R5 watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int t0;
    logic signed [5:0] held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #5;
    chk(out_valid == 1'b0, "R12 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R12 in_ready after reset", in_ready, 1);
    chk(err_overdeg == 1'b0, "R12 err after reset", err_overdeg, 0);

    mode = 0;
    t0 = cyc;
    run_table();
    drain();
    chk((last_out - t0) <= 70, "R7 overlapped throughput cycles", last_out - t0, 70);

    mode = 1;
    run_table();
    drain();
    mode = 0;

    // R9: stray message with no node open
    send_msg(1'b0, 3, -1);
    repeat (5) @(posedge clk);
    chk(out_valid == 1'b0, "R9 stray message produced output", out_valid, 0);
    push(3, 1, 0, "R9 node after stray"); push(2, 0, 1, "R9 node after stray");
    send_msg(1'b1, 2, 3); send_msg(1'b0, 2, 5);
    drain();

    // R10: partial node abandoned by a new first message
    send_msg(1'b1, 6, -1); send_msg(1'b0, 6, 2); send_msg(1'b0, 6, 3);
    push(9, 1, 0, "R10 restart"); push(-15, 0, 1, "R10 restart");
    send_msg(1'b1, 2, -20); send_msg(1'b0, 2, 12);
    drain();

    // R8: over-degree node
    err_seen = 0;
    push(9, 1, 0, "R8 overdeg edge0");
    for (int e = 1; e < 8; e++) push(6, 0, e == 7, "R8 overdeg edge");
    send_msg(1'b1, 10, 8);
    send_msg(1'b0, 10, 12);
    for (int e = 2; e < 8; e++) send_msg(1'b0, 10, 12 + e);
    send_msg(1'b0, 10, 1); send_msg(1'b0, 10, -1);
    drain();
    chk(err_seen == 2, "R8 error pulses", err_seen, 2);
    push(-1, 1, 0, "R8 node closed after degree"); push(9, 0, 1, "R8 node closed after degree");
    send_msg(1'b1, 2, 13); send_msg(1'b0, 2, -2);
    drain();

    // R7 / R11: both register sets occupied
    mode = 2;
    push(-6, 1, 0, "R7 held node A"); push(3, 0, 1, "R7 held node A");
    push(7, 1, 0, "R7 held node B"); push(7, 0, 1, "R7 held node B");
    send_msg(1'b1, 2, 4); send_msg(1'b0, 2, -8);
    send_msg(1'b1, 2, 10); send_msg(1'b0, 2, 10);
    @(negedge clk);
    in_valid = 1'b1; in_first = 1'b1; in_deg = 4'd1; in_llr = 6'sd5;
    #5;
    chk(in_ready == 1'b0, "R7 in_ready with both sets full", in_ready, 0);
    held = out_llr;
    repeat (3) @(negedge clk);
    #5;
    chk(out_valid == 1'b1, "R11 out_valid held", out_valid, 1);
    chk(out_llr == held, "R11 out_llr held", int'(out_llr), int'(held));
    chk(in_ready == 1'b0, "R7 in_ready still low", in_ready, 0);
    in_valid = 1'b0;
    mode = 0;
    drain();

    summary();
    $finish;
  end
endmodule